// File: doc/BRIEF.md
# Serial PMIC Register-Access Bridge

This block lets a host on a simple memory-mapped bus reach the 16-bit registers of an external power-management chip over a four-wire serial link. A host store that lands inside the slave window is turned into a queued write: the slave register address is taken from the store offset and the data from the low 16 bits. Queued writes wait in a small FIFO. A sequencer drains the FIFO one serial frame at a time.

A read starts when the host stores a slave offset into the read-command register. No separate start bit is needed. The busy flag in the read-data register rises on the clock edge that takes the command. The sequencer holds the read back until every write queued ahead of it has gone out. It then runs a read frame and returns the 16-bit value together with an echo of the 15-bit slave address, so the host can check the word belongs to its request.

The sequencer has three states. `SQ_IDLE` picks the next job. `SQ_WRITE` and `SQ_READ` wait for the end of the frame that is running. The transitions are:
- `SQ_IDLE` to `SQ_WRITE` when the FIFO holds an entry. The head entry is popped and a write frame is launched.
- `SQ_IDLE` to `SQ_READ` when the FIFO is empty and a read is pending. A read frame is launched.
- `SQ_WRITE` or `SQ_READ` back to `SQ_IDLE` when the shift engine reports that the frame is done.

Top module: `pmic_link_bridge`

## Requirements
- R1: After reset, the status register (0x30) reads exactly 0x400: empty (bit 10) is 1, full (bit 11) is 0 and overflow (bit 0) is 0. The read-data register (0x2C) reads 0. The chip select `ser_cs_n` is high and `ser_clk` is low.
- R2: A store of an in-range offset to 0x28 while no read is pending starts a read. Bit 31 of 0x2C reads 1 from the first cycle after that store's clock edge until the read completes, and then reads 0.
- R3: When a read completes, 0x2C holds the slave register value in bits 15:0 and the echoed 15-bit slave address in bits 30:16. The address is command bits 16:2 when `NEW_MODE`=1 and command bits 14:0 when `NEW_MODE`=0.
- R4: A store to `WIN_BASE`+off with off < `WIN_BYTES` queues a write of data bits 15:0 to the slave address taken from off with the same mapping as R3. `WIN_BASE`/`WIN_BYTES` are 0x20000/0x20000 when `NEW_MODE`=1 and 0x8000/0x1000 when `NEW_MODE`=0. A store at or past the window end queues nothing.
- R5: The write FIFO holds `FIFO_DEPTH` entries. Status bit 11 is 1 exactly when it is full and status bit 10 is 1 exactly when it is empty.
- R6: A window store that arrives while the FIFO is full is dropped and sets the sticky overflow flag in status bit 0. Only a store to 0x30 clears that flag.
- R7: A read frame starts only when the write FIFO is empty, so a read always returns the effect of every write queued before its command.
- R8: A read command that arrives while a read is pending, or whose offset is not below `WIN_BYTES`, is ignored.
- R9: Each serial frame holds `ser_cs_n` low for 32 `ser_clk` periods of 2×`CLK_DIV` clock cycles. The bits are, in order: one direction bit (1 = read, 0 = write), 15 address bits and 16 data bits, MSB first. `ser_mosi` changes only on falling `ser_clk`, and `ser_miso` is sampled on rising `ser_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host store strobe |
| bus_addr | input | HADDR_W | Host store byte address |
| bus_wdata | input | 32 | Host store data |
| bus_raddr | input | HADDR_W | Host load byte address |
| bus_rdata | output | 32 | Host load data (combinational) |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_cs_n | output | 1 | Serial frame select, active low |
| ser_mosi | output | 1 | Serial data to the slave |
| ser_miso | input | 1 | Serial data from the slave |

## Verification
The busy flag and the FIFO status bits are due in the first cycle after the clock edge that accepts a store. The bench therefore samples them at the following falling edge and never later.

A read result only becomes final after the writes queued ahead of it have each taken a full frame, plus one launch cycle and one done cycle. Rather than guess that count, the bench polls bit 31 at falling edges within a bounded window.

Serial frames are scored as they finish at the slave model, against a queue that the driver tasks fill in issue order. A frame that is missing, extra or out of order is reported against R7 or R9.

// File: rtl/pmic_link_pkg.sv
package pmic_link_pkg;

    localparam int SLV_ADDR_W = 15;
    localparam int SLV_DATA_W = 16;
    localparam int FRAME_BITS = 1 + SLV_ADDR_W + SLV_DATA_W;

    localparam int REG_RDCMD  = 'h28;
    localparam int REG_RDDATA = 'h2C;
    localparam int REG_STATUS = 'h30;

    localparam int STAT_FULL  = 11;
    localparam int STAT_EMPTY = 10;
    localparam int STAT_OVF   = 0;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WRITE = 2'd1,
        SQ_READ  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [SLV_ADDR_W-1:0] addr;
        logic [SLV_DATA_W-1:0] data;
    } wr_item_t;

endpackage

// File: rtl/pmic_wr_fifo.sv
module pmic_wr_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/pmic_shift_engine.sv
module pmic_shift_engine
    import pmic_link_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  rw,
    input  logic [SLV_ADDR_W-1:0] addr,
    input  logic [SLV_DATA_W-1:0] wdata,
    output logic [SLV_DATA_W-1:0] rdata,
    output logic                  done,
    output logic                  sclk,
    output logic                  cs_n,
    output logic                  mosi,
    input  logic                  miso
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BW = $clog2(FRAME_BITS);

    logic                  active;
    logic [FRAME_BITS-1:0] sh;
    logic [SLV_DATA_W-1:0] rx;
    logic [CW-1:0]         cnt;
    logic [BW-1:0]         bidx;

    assign mosi  = sh[FRAME_BITS-1];
    assign rdata = rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            sh     <= '0;
            rx     <= '0;
            cnt    <= '0;
            bidx   <= '0;
            sclk   <= 1'b0;
            cs_n   <= 1'b1;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    cs_n   <= 1'b0;
                    sclk   <= 1'b0;
                    sh     <= {rw, addr, wdata};
                    cnt    <= '0;
                    bidx   <= '0;
                end
            end else if (cnt == CW'(DIV - 1)) begin
                cnt <= '0;
                if (!sclk) begin
                    // rising edge: capture slave data
                    sclk <= 1'b1;
                    rx   <= {rx[SLV_DATA_W-2:0], miso};
                end else begin
                    // falling edge: launch next bit or close the frame
                    sclk <= 1'b0;
                    if (bidx == BW'(FRAME_BITS - 1)) begin
                        active <= 1'b0;
                        cs_n   <= 1'b1;
                        done   <= 1'b1;
                    end else begin
                        bidx <= bidx + 1'b1;
                        sh   <= {sh[FRAME_BITS-2:0], 1'b0};
                    end
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pmic_link_bridge.sv
module pmic_link_bridge
    import pmic_link_pkg::*;
#(
    parameter int NEW_MODE   = 1,
    parameter int FIFO_DEPTH = 8,
    parameter int CLK_DIV    = 2,
    parameter int HADDR_W    = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [HADDR_W-1:0] bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [HADDR_W-1:0] bus_raddr,
    output logic [31:0]        bus_rdata,
    output logic               ser_clk,
    output logic               ser_cs_n,
    output logic               ser_mosi,
    input  logic               ser_miso
);
    localparam int WIN_BASE  = (NEW_MODE != 0) ? 'h20000 : 'h8000;
    localparam int WIN_BYTES = (NEW_MODE != 0) ? 'h20000 : 'h1000;
    localparam int ITEM_W    = $bits(wr_item_t);

    function automatic logic [SLV_ADDR_W-1:0] map_addr(input logic [31:0] off);
        return (NEW_MODE != 0) ? off[16:2] : off[14:0];
    endfunction

    // host decode
    logic [HADDR_W-1:0] win_off;
    logic               in_win, win_wr, cmd_wr, stat_wr, cmd_ok;

    assign win_off = bus_addr - HADDR_W'(WIN_BASE);
    assign in_win  = (bus_addr >= HADDR_W'(WIN_BASE)) && (win_off < HADDR_W'(WIN_BYTES));
    assign win_wr  = bus_wr && in_win;
    assign cmd_wr  = bus_wr && (bus_addr == HADDR_W'(REG_RDCMD));
    assign stat_wr = bus_wr && (bus_addr == HADDR_W'(REG_STATUS));
    assign cmd_ok  = (bus_wdata < 32'(WIN_BYTES));

    // write queue
    wr_item_t fifo_in, fifo_head;
    logic     fifo_push, fifo_pop, fifo_full, fifo_empty;

    assign fifo_in.addr = map_addr(32'(win_off));
    assign fifo_in.data = bus_wdata[SLV_DATA_W-1:0];
    assign fifo_push    = win_wr && !fifo_full;

    pmic_wr_fifo #(.DEPTH(FIFO_DEPTH), .W(ITEM_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   (fifo_in),
        .dout  (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // serial engine
    logic                  eng_start, eng_rw, eng_done;
    logic [SLV_ADDR_W-1:0] eng_addr;
    logic [SLV_DATA_W-1:0] eng_wdata, eng_rdata;

    pmic_shift_engine #(.DIV(CLK_DIV)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .rw    (eng_rw),
        .addr  (eng_addr),
        .wdata (eng_wdata),
        .rdata (eng_rdata),
        .done  (eng_done),
        .sclk  (ser_clk),
        .cs_n  (ser_cs_n),
        .mosi  (ser_mosi),
        .miso  (ser_miso)
    );

    // sequencer
    seq_state_t state_q, state_d;
    logic       rd_busy, ovf_q;
    logic [SLV_ADDR_W-1:0] rd_addr_q, rd_echo_q;
    logic [SLV_DATA_W-1:0] rd_val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (!fifo_empty)  state_d = SQ_WRITE;
                else if (rd_busy) state_d = SQ_READ;
            end
            SQ_WRITE: if (eng_done) state_d = SQ_IDLE;
            SQ_READ:  if (eng_done) state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        eng_start = 1'b0;
        eng_rw    = 1'b0;
        eng_addr  = '0;
        eng_wdata = '0;
        fifo_pop  = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (!fifo_empty) begin
                    eng_start = 1'b1;
                    fifo_pop  = 1'b1;
                    eng_addr  = fifo_head.addr;
                    eng_wdata = fifo_head.data;
                end else if (rd_busy) begin
                    eng_start = 1'b1;
                    eng_rw    = 1'b1;
                    eng_addr  = rd_addr_q;
                end
            end
            SQ_WRITE: ;
            SQ_READ:  ;
        endcase
    end

    // host-visible state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_busy   <= 1'b0;
            rd_addr_q <= '0;
            rd_echo_q <= '0;
            rd_val_q  <= '0;
            ovf_q     <= 1'b0;
        end else begin
            if (cmd_wr && cmd_ok && !rd_busy) begin
                rd_busy   <= 1'b1;
                rd_addr_q <= map_addr(bus_wdata);
            end else if (state_q == SQ_READ && eng_done) begin
                rd_busy   <= 1'b0;
                rd_val_q  <= eng_rdata;
                rd_echo_q <= rd_addr_q;
            end
            if (win_wr && fifo_full) ovf_q <= 1'b1;
            else if (stat_wr)        ovf_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_raddr == HADDR_W'(REG_RDDATA)) begin
            bus_rdata = {rd_busy, rd_echo_q, rd_val_q};
        end else if (bus_raddr == HADDR_W'(REG_STATUS)) begin
            bus_rdata[STAT_FULL]  = fifo_full;
            bus_rdata[STAT_EMPTY] = fifo_empty;
            bus_rdata[STAT_OVF]   = ovf_q;
        end
    end
endmodule

// File: rtl/pmic_link_chk.sv
module pmic_link_chk #(
    parameter int HADDR_W = 19,
    parameter int WIN_SIZE = 'h20000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [HADDR_W-1:0] bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               busy,
    input logic               ovf,
    input logic               full,
    input logic               empty,
    input logic               done,
    input logic               sclk,
    input logic               cs_n,
    input logic               mosi
);
    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == HADDR_W'('h28) && bus_wdata < 32'(WIN_SIZE) && !busy) |=> busy);

    // R2
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R5
    full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(bus_wr && bus_addr == HADDR_W'('h30))) |=> ovf);

    // R9
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R9
    idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
endmodule

bind pmic_link_bridge pmic_link_chk #(.HADDR_W(HADDR_W), .WIN_SIZE(WIN_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (rd_busy),
    .ovf       (ovf_q),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .done      (eng_done),
    .sclk      (ser_clk),
    .cs_n      (ser_cs_n),
    .mosi      (ser_mosi)
);

// File: tb/tb_pmic_link_bridge.sv
`timescale 1ns/1ps
module tb_pmic_link_bridge;
    localparam int AW = 19;
    localparam int WBASE = 'h20000;
    localparam int WSIZE = 'h20000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0, bus_raddr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic ser_clk, ser_cs_n, ser_mosi;
    logic ser_miso = 1'b0;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pmic_link_bridge dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .ser_clk(ser_clk), .ser_cs_n(ser_cs_n), .ser_mosi(ser_mosi), .ser_miso(ser_miso)
    );

    // slave register model and expected copy
    logic [15:0] smem [64];
    logic [15:0] emem [64];
    logic [31:0] exp_q [$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural slave + scoreboard monitor
    int nb = 0;
    logic [31:0] shin = '0;
    logic [15:0] rdword = '0;
    always @(negedge ser_cs_n) nb = 0;
    always @(posedge ser_clk) if (!ser_cs_n) begin
        shin = {shin[30:0], ser_mosi};
        nb++;
        if (nb == 16) rdword = smem[shin[5:0]];
        if (nb == 32) begin
            logic [31:0] got, want;
            got = shin[31] ? {shin[31:16], rdword} : shin;
            if (!shin[31]) smem[shin[21:16]] = shin[15:0];
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected frame", got, 32'h0);
            end else begin
                want = exp_q.pop_front();
                check(got == want, "R9/R7 frame content/order", got, want);
            end
        end
    end
    always @(negedge ser_clk) if (!ser_cs_n && nb >= 16 && nb < 32) ser_miso = rdword[31 - nb];

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        bus_raddr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic win_write(input logic [14:0] sa, input logic [15:0] d);
        exp_q.push_back({1'b0, sa, d});
        emem[sa[5:0]] = d;
        bus_write(AW'(WBASE) + AW'({sa, 2'b00}), {16'hDEAD, d});
    endtask

    task automatic start_read(input logic [14:0] sa);
        exp_q.push_back({1'b1, sa, emem[sa[5:0]]});
        bus_write(AW'('h28), {15'd0, sa, 2'b00});
    endtask

    task automatic wait_read(output logic [31:0] w);
        w = 32'hFFFF_FFFF;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            bus_read(AW'('h2C), w);
            if (!w[31]) break;
        end
    endtask

    task automatic wait_quiet();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            bus_read(AW'('h30), s);
            if (s[10] && ser_cs_n) begin
                bus_read(AW'('h2C), s);
                if (!s[31]) break;
            end
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, w;
        logic [15:0] e;
        for (int i = 0; i < 64; i++) begin
            smem[i] = 16'hA500 ^ 16'(i * 37);
            emem[i] = smem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(AW'('h30), v);
        check(v == 32'h400, "R1 status after reset", v, 32'h400);
        bus_read(AW'('h2C), v);
        check(v == 32'h0, "R1 read-data after reset", v, 32'h0);
        check(ser_cs_n && !ser_clk, "R1 serial idle", {ser_cs_n, ser_clk}, 2'b10);

        // R2 busy visible right after command, R3 result
        e = emem[5];
        start_read(15'd5);
        bus_read(AW'('h2C), v);
        check(v[31], "R2 busy after command", v, 32'h8000_0000);
        wait_read(w);
        check(w == {1'b0, 15'd5, e}, "R3 read word", w, {1'b0, 15'd5, e});

        // R3 top of the address range
        e = emem[63];
        start_read(15'h7FFF);
        wait_read(w);
        check(w == {1'b0, 15'h7FFF, e}, "R3 echo at highest address", w, {1'b0, 15'h7FFF, e});

        // R7 read issued right after a write sees the new value; R4 window write
        win_write(15'd3, 16'h1234);
        start_read(15'd3);
        wait_read(w);
        check(w == {1'b0, 15'd3, 16'h1234}, "R7 read after queued write", w, {1'b0, 15'd3, 16'h1234});
        wait_quiet();

        // R4 store at the window end is ignored
        bus_write(AW'(WBASE + WSIZE), 32'h5555);
        bus_read(AW'('h30), v);
        check(v[10] && !v[11], "R4 out-of-window store queues nothing", v, 32'h400);
        repeat (20) @(negedge clk);
        check(ser_cs_n, "R4 no frame for out-of-window store", ser_cs_n, 1);

        // R8 out-of-range read command ignored
        bus_write(AW'('h28), 32'(WSIZE));
        bus_read(AW'('h2C), v);
        check(!v[31], "R8 out-of-range command ignored", v, {1'b0, 15'h7FFF, emem[63]});

        // R8 command while busy ignored
        e = emem[7];
        start_read(15'd7);
        bus_write(AW'('h28), 32'(9 << 2));
        wait_read(w);
        check(w == {1'b0, 15'd7, e}, "R8 second command while busy ignored", w, {1'b0, 15'd7, e});
        wait_quiet();

        // R5 / R6 fill the FIFO back to back: 1 goes out, 8 fill it, 10th drops
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            bus_wr = 1'b1;
            bus_addr = AW'(WBASE) + AW'((20 + i) << 2);
            bus_wdata = 32'(16'hC000 + i);
            if (i < 9) begin
                exp_q.push_back({1'b0, 15'(20 + i), 16'(16'hC000 + i)});
                emem[20 + i] = 16'(16'hC000 + i);
            end
            if (i == 9) begin
                bus_read(AW'('h30), v);
                check(v[11] && !v[10], "R5 full after depth+1 stores", v, 32'h800);
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(AW'('h30), v);
        check(v[0] && v[11], "R6 overflow flag set on store while full", v, 32'h801);
        wait_quiet();
        bus_read(AW'('h30), v);
        check(v == 32'h401, "R6 overflow sticky after drain", v, 32'h401);

        e = emem[29];
        start_read(15'd29);
        wait_read(w);
        check(w == {1'b0, 15'd29, e}, "R6 dropped store did not reach slave", w, {1'b0, 15'd29, e});
        start_read(15'd28);
        wait_read(w);
        check(w == {1'b0, 15'd28, 16'hC008}, "R4 last accepted store reached slave", w, {1'b0, 15'd28, 16'hC008});

        bus_write(AW'('h30), 32'h0);
        bus_read(AW'('h30), v);
        check(v == 32'h400, "R6 overflow cleared by status store", v, 32'h400);

        wait_quiet();
        check(exp_q.size() == 0, "R9 all expected frames seen", exp_q.size(), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule